// File: doc/BRIEF.md
# Performance Event Counter Unit

This block counts cycles and selected events for performance analysis. It holds three 32-bit counters: a cycle counter and two event counters. A single 32-bit control word sets the global enable, the prescaler, the interrupt enables, the event export and the event code for each event counter. It also carries the sticky overflow flags and the counter clear commands.

A narrow register port reaches the control word and the three counters. Writes take effect at the next clock edge and reads are combinational. Each event counter picks its per-cycle increment from a bank of event inputs, from two auxiliary signals or from a constant-one source, according to its 8-bit code. When a counter wraps it sets its overflow flag. If that counter's interrupt is enabled, the active-low interrupt line goes low. Software can preload a counter so that it overflows after a chosen number of events.

Top module: `perf_counter_unit`

## Requirements
- R1: After reset, the control word, all three counters and the overflow flags read 0, `irq_n` is 1 and `evt_export` is 0.
- R2: Register address 0 is the control word, 1 the cycle counter, 2 event counter 0 and 3 event counter 1. Control bit 3 selects divide, bits 6..4 are the interrupt enables (counter 0, counter 1, cycle), bits 10..8 the overflow flags in the same order, bit 11 the export enable, bits 19:12 the event code of counter 1 and bits 27:20 the event code of counter 0. Bits 1, 2, 7 and 31..28 always read 0. Counter registers read back what was written.
- R3: While control bit 0 (global enable) is 0, no counter and no prescaler advances.
- R4: With the enable set, the cycle counter adds 1 every clock when bit 3 is 0. When bit 3 is 1 it adds 1 on every 64th enabled clock, counted from the last prescaler clear.
- R5: Event codes 0x00..NUM_EVT-1 add `evt_in[code]`. Code 0x20 adds `aux_evt[0]`, 0x21 adds `aux_evt[1]`, 0x22 adds the number of asserted `aux_evt` bits (0, 1 or 2), and 0xFF adds 1 every cycle. Every other code adds nothing.
- R6: A counter that passes 0xFFFFFFFF wraps modulo 2^32, keeps counting and sets its overflow flag.
- R7: Overflow flags stay set until a control write has 1 in the flag's bit and 1 in bit 0. A 0 in the flag bit, or a 0 in bit 0, leaves the flag set.
- R8: A control write with bit 1 set clears both event counters. A control write with bit 2 set clears the cycle counter and the prescaler. Neither command touches the other counters.
- R9: `irq_n` is 0 exactly when some overflow flag is set together with its interrupt enable bit.
- R10: `evt_export` equals `evt_in` while bit 11 is 1 and is 0 otherwise.
- R11: A counter write made in a cycle where that counter would increment loads the written value exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational) |
| evt_in | input | NUM_EVT | Per-cycle event inputs |
| aux_evt | input | 2 | Auxiliary event signals |
| irq_n | output | 1 | Overflow interrupt, active low |
| evt_export | output | NUM_EVT | Gated copy of the event inputs |

## Verification
The bench builds the block with its default parameters: 32-bit counters, sixteen event inputs and a prescale of 64. With sixteen inputs, code 0x10 is the first unused code, so the boundary between decoded and reserved codes can be tested directly. A prescale of 64 is short enough to observe the 63rd and 64th enabled cycles around the first divided tick. The 32-bit wrap is reached by preloading a counter just below the maximum.

// File: rtl/perf_counter_unit.sv
module perf_counter_unit #(
  parameter int DATA_W   = 32,
  parameter int NUM_EVT  = 16,
  parameter int PRESCALE = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [1:0]         reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic [1:0]         aux_evt,
  output logic               irq_n,
  output logic [NUM_EVT-1:0] evt_export
);
  localparam int PS_W = $clog2(PRESCALE);
  localparam logic [PS_W-1:0] PS_MAX = PS_W'(PRESCALE - 1);

  logic              en_q, div_q, exp_q;
  logic [2:0]        ie_q, ovf_q;
  logic [7:0]        sel0_q, sel1_q;
  logic [PS_W-1:0]   psc_q;
  logic [DATA_W-1:0] cyc_q, ev0_q, ev1_q;

  function automatic logic [1:0] evt_inc(input logic [7:0] code,
                                         input logic [NUM_EVT-1:0] ev,
                                         input logic [1:0] ax);
    logic [1:0] r;
    r = 2'd0;
    if (code == 8'hFF) r = 2'd1;
    else if (code == 8'h20) r = {1'b0, ax[0]};
    else if (code == 8'h21) r = {1'b0, ax[1]};
    else if (code == 8'h22) r = 2'(ax[0]) + 2'(ax[1]);
    else
      for (int i = 0; i < NUM_EVT; i++)
        if (code == 8'(i)) r = {1'b0, ev[i]};
    return r;
  endfunction

  wire ctrl_wr = reg_we && reg_addr == 2'd0;
  wire wr_cyc  = reg_we && reg_addr == 2'd1;
  wire wr_ev0  = reg_we && reg_addr == 2'd2;
  wire wr_ev1  = reg_we && reg_addr == 2'd3;
  wire clr_ev  = ctrl_wr && reg_wdata[1];
  wire clr_cyc = ctrl_wr && reg_wdata[2];

  wire [1:0] inc0 = en_q ? evt_inc(sel0_q, evt_in, aux_evt) : 2'd0;
  wire [1:0] inc1 = en_q ? evt_inc(sel1_q, evt_in, aux_evt) : 2'd0;
  wire cyc_tick   = en_q && (!div_q || psc_q == PS_MAX);

  wire [DATA_W:0] sum0 = {1'b0, ev0_q} + (DATA_W+1)'(inc0);
  wire [DATA_W:0] sum1 = {1'b0, ev1_q} + (DATA_W+1)'(inc1);
  wire [DATA_W:0] sumc = {1'b0, cyc_q} + (DATA_W+1)'(cyc_tick);

  wire [2:0] wrap = {sumc[DATA_W] && !wr_cyc && !clr_cyc,
                     sum1[DATA_W] && !wr_ev1 && !clr_ev,
                     sum0[DATA_W] && !wr_ev0 && !clr_ev};
  wire [2:0] w1c  = (ctrl_wr && reg_wdata[0]) ? reg_wdata[10:8] : 3'b000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; div_q <= 1'b0; exp_q <= 1'b0;
      ie_q <= '0; ovf_q <= '0; sel0_q <= '0; sel1_q <= '0;
      psc_q <= '0; cyc_q <= '0; ev0_q <= '0; ev1_q <= '0;
    end else begin
      if (ctrl_wr) begin
        en_q   <= reg_wdata[0];
        div_q  <= reg_wdata[3];
        ie_q   <= reg_wdata[6:4];
        exp_q  <= reg_wdata[11];
        sel1_q <= reg_wdata[19:12];
        sel0_q <= reg_wdata[27:20];
      end
      ovf_q <= (ovf_q & ~w1c) | wrap;

      if (clr_cyc) psc_q <= '0;
      else if (en_q && div_q) psc_q <= (psc_q == PS_MAX) ? '0 : psc_q + 1'b1;

      if (wr_cyc) cyc_q <= reg_wdata;
      else if (clr_cyc) cyc_q <= '0;
      else cyc_q <= sumc[DATA_W-1:0];

      if (wr_ev0) ev0_q <= reg_wdata;
      else if (clr_ev) ev0_q <= '0;
      else ev0_q <= sum0[DATA_W-1:0];

      if (wr_ev1) ev1_q <= reg_wdata;
      else if (clr_ev) ev1_q <= '0;
      else ev1_q <= sum1[DATA_W-1:0];
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = DATA_W'({4'b0, sel0_q, sel1_q, exp_q, ovf_q, 1'b0,
                                    ie_q, div_q, 2'b00, en_q});
      2'd1:    reg_rdata = cyc_q;
      2'd2:    reg_rdata = ev0_q;
      default: reg_rdata = ev1_q;
    endcase
  end

  assign irq_n      = ~|(ovf_q & ie_q);
  assign evt_export = exp_q ? evt_in : '0;

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !reg_we) |=> ($stable(cyc_q) && $stable(ev0_q) && $stable(ev1_q) && $stable(psc_q)));

  p_div_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && div_q && !reg_we && psc_q != PS_MAX) |=> $stable(cyc_q));

  p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_we && ev0_q == '1 && inc0 != 2'd0) |=> ovf_q[0]);

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q[0] && !(ctrl_wr && reg_wdata[0] && reg_wdata[8])) |=> ovf_q[0]);

  p_wrprio_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 2'd2) |=> ev0_q == $past(reg_wdata));
endmodule

// File: tb/perf_counter_unit_test.sv
module perf_counter_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] evt_in = '0;
  logic [1:0]  aux_evt = '0;
  logic        irq_n;
  logic [15:0] evt_export;
  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  perf_counter_unit uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in),
    .aux_evt(aux_evt), .irq_n(irq_n), .evt_export(evt_export));

  typedef struct packed {
    logic [7:0]  s0;
    logic [7:0]  s1;
    logic [15:0] ev;
    logic [1:0]  ax;
    logic [31:0] e0;
    logic [31:0] e1;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{8'h03, 8'h05, 16'h0008, 2'b00, 32'd10, 32'd0},
    '{8'h22, 8'h20, 16'h0000, 2'b11, 32'd20, 32'd10},
    '{8'h21, 8'hFF, 16'h0000, 2'b10, 32'd10, 32'd10},
    '{8'h40, 8'h10, 16'hFFFF, 2'b11, 32'd0,  32'd0},
    '{8'h0F, 8'h00, 16'h8001, 2'b00, 32'd10, 32'd10},
    '{8'h22, 8'h0E, 16'h4000, 2'b01, 32'd10, 32'd10}
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a;
    #1;
    check(reg_rdata, exp, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(2'd0, 32'h0, "R1 ctrl");
    rd(2'd1, 32'h0, "R1 cyc");
    rd(2'd2, 32'h0, "R1 ev0");
    rd(2'd3, 32'h0, "R1 ev1");
    check({31'b0, irq_n}, 32'd1, "R1 irq_n");
    check({16'b0, evt_export}, 32'd0, "R1 export");

    // table: every vector runs 10 enabled edges
    foreach (VECS[i]) begin
      evt_in = VECS[i].ev; aux_evt = VECS[i].ax;
      wr(2'd0, {4'b0, VECS[i].s0, VECS[i].s1, 12'h006});
      wr(2'd0, {4'b0, VECS[i].s0, VECS[i].s1, 12'h001});
      repeat (9) @(negedge clk);
      wr(2'd0, {4'b0, VECS[i].s0, VECS[i].s1, 12'h000});
      rd(2'd2, VECS[i].e0, "R5 ev0");
      rd(2'd3, VECS[i].e1, "R5 ev1");
      rd(2'd1, 32'd10, "R4 cyc every clock");
    end

    // R3: disabled, nothing moves
    evt_in = '1; aux_evt = 2'b11;
    wr(2'd0, 32'h0FF0_0000);
    repeat (20) @(negedge clk);
    rd(2'd1, 32'd10, "R3 cyc held");
    rd(2'd2, 32'd10, "R3 ev0 held");

    // R2: field layout and readback
    wr(2'd0, 32'hFFFF_FFFE);
    rd(2'd0, 32'h0FFF_F878, "R2 ctrl layout");
    wr(2'd1, 32'h1234_5678);
    rd(2'd1, 32'h1234_5678, "R2 cyc readback");
    wr(2'd3, 32'hCAFE_0001);
    rd(2'd3, 32'hCAFE_0001, "R2 ev1 readback");

    // R10: export gating
    evt_in = 16'hA5A5; #1;
    check({16'b0, evt_export}, 32'h0000_A5A5, "R10 export on");
    wr(2'd0, 32'h0);
    check({16'b0, evt_export}, 32'h0, "R10 export off");

    // R8: separate clears
    wr(2'd2, 32'd77);
    wr(2'd0, 32'h2);
    rd(2'd2, 32'd0, "R8 ev0 cleared");
    rd(2'd3, 32'd0, "R8 ev1 cleared");
    rd(2'd1, 32'h1234_5678, "R8 cyc untouched");
    rd(2'd0, 32'h0, "R8 clear bits read 0");

    // R4: divide by 64 from a fresh prescaler
    wr(2'd0, 32'h0000_000D);
    repeat (63) @(negedge clk);
    rd(2'd1, 32'd0, "R4 before 64th");
    @(negedge clk);
    rd(2'd1, 32'd1, "R4 at 64th");
    repeat (63) @(negedge clk);
    wr(2'd0, 32'h0000_0008);
    rd(2'd1, 32'd2, "R4 second tick");

    // R6/R7/R9: overflow on event counter 0
    wr(2'd2, 32'hFFFF_FFFE);
    wr(2'd0, 32'h0FF0_0011);
    @(negedge clk);
    check({31'b0, irq_n}, 32'd1, "R9 no flag yet");
    @(negedge clk);
    rd(2'd2, 32'd0, "R6 wrapped");
    check({31'b0, irq_n}, 32'd0, "R9 irq asserted");
    wr(2'd0, 32'h0FF0_0010);
    rd(2'd2, 32'd1, "R6 keeps counting");
    rd(2'd0, 32'h0FF0_0110, "R6 flag set");
    wr(2'd0, 32'h0FF0_0110);
    rd(2'd0, 32'h0FF0_0110, "R7 clear ignored while disabled");
    wr(2'd0, 32'h0FF0_0011);
    rd(2'd0, 32'h0FF0_0111, "R7 zero write no effect");
    check({31'b0, irq_n}, 32'd0, "R9 still low");
    wr(2'd0, 32'h0FF0_0111);
    rd(2'd0, 32'h0FF0_0011, "R7 flag cleared");
    check({31'b0, irq_n}, 32'd1, "R9 released");
    wr(2'd0, 32'h0);

    // R9: cycle counter flag masked until enabled
    wr(2'd1, 32'hFFFF_FFFF);
    wr(2'd0, 32'h1);
    wr(2'd0, 32'h0);
    rd(2'd0, 32'h0000_0400, "R6 cyc flag");
    check({31'b0, irq_n}, 32'd1, "R9 masked");
    wr(2'd0, 32'h40);
    check({31'b0, irq_n}, 32'd0, "R9 unmasked");
    wr(2'd0, 32'h441);
    wr(2'd0, 32'h0);
    check({31'b0, irq_n}, 32'd1, "R9 cleared");

    // R11: write beats increment
    wr(2'd0, 32'h0FF0_0001);
    repeat (3) @(negedge clk);
    wr(2'd2, 32'h0000_0100);
    rd(2'd2, 32'h0000_0100, "R11 write priority");
    wr(2'd0, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule